// File: doc/BRIEF.md
# Status Register and Write-Protect Gate

This block sits behind the serial front end of a flash memory slave. It holds the 8-bit status register. For every decoded command it decides whether that command may run. The front end presents a command once chip select has risen. The command arrives as an opcode, a flag telling whether the transfer ended on a whole byte, the target address and the data byte. The gate weighs the following:

- the write-enable latch;
- the busy lockout;
- the block-protect level;
- the status-protect bit together with the write-protect pin;
- the sleep state.

It then answers with a one-cycle enable towards the read path, the program engine, the erase engine, the status-write path or the power manager.

The busy flag rises when a write-class command is accepted. It falls on a done pulse from the array timer, and the write-enable latch clears with it. Block protection maps a 3-bit level onto the upper part of the address space. After a release from sleep, a fixed recovery window passes before any command is taken again.

Top module: `flash_status_gate`

## Requirements
- R1: Status layout: bit 0 is BUSY, bit 1 is WEL, bits 4:2 are the protect level BP, bit 7 is SRP. Bits 6:5 always read 0. The value after reset is 00h.
- R2: Opcode 06h sets WEL and opcode 04h clears it.
- R3: The write-class opcodes are 02h page program, 52h parameter program, D8h sector erase, C7h chip erase, D5h parameter erase and 01h status write. Each is accepted only while WEL = 1. On acceptance, the enable (en_prog for 02h/52h, en_erase for D8h/C7h/D5h, en_stat_wr for 01h) pulses for one cycle in the cycle after the command, and BUSY reads 1 from that same cycle.
- R4: An op_done pulse while BUSY = 1 clears BUSY and WEL in the next cycle. BUSY holds until that pulse arrives. An op_done pulse while BUSY = 0 has no effect.
- R5: While BUSY = 1, only 05h is accepted (en_read pulses). Every other opcode, 06h and 04h included, has no effect.
- R6: Every non-read command is discarded when cmd_aligned = 0. The read opcodes are accepted whatever cmd_aligned is.
- R7: An accepted 01h loads SRP from data bit 7 and BP from data bits 4:2. No other status bit changes. The command is rejected, leaving the status unchanged, while SRP = 1 and wp_n = 0.
- R8: For a nonzero BP = n, the top 2^ADDR_W >> (7-n) bytes are protected. Page program to a protected address is rejected. Sector erase is rejected if the last byte of its 2^SECTOR_W-byte sector is protected. Chip erase is rejected whenever BP != 0. A rejection leaves WEL and BUSY unchanged. Parameter-page commands are not subject to BP.
- R9: Opcode B9h pulses en_pdown and raises asleep. While asleep, every opcode except ABh is ignored, 05h included. ABh starts a recovery window: asleep stays high for WAKE_CYCLES cycles after the release cycle, and commands are accepted once it falls.
- R10: While idle and awake, the read opcodes produce an en_read pulse. These are 05h, 03h, 0Bh, 53h, 5Bh, 90h, 9Fh and ABh. Unknown opcodes produce nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: a command has ended (chip select rose) |
| cmd_op | input | 8 | Decoded opcode |
| cmd_aligned | input | 1 | Chip select rose after a whole number of bytes |
| cmd_addr | input | ADDR_W | Target address of the command |
| cmd_wdata | input | 8 | Data byte for a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| op_done | input | 1 | Done pulse from the array cycle timer |
| status_o | output | 8 | Status register |
| en_read | output | 1 | Read-class command accepted |
| en_prog | output | 1 | Program command accepted |
| en_erase | output | 1 | Erase command accepted |
| en_stat_wr | output | 1 | Status write accepted |
| en_pdown | output | 1 | Sleep command accepted |
| asleep | output | 1 | Asleep or inside the recovery window |

## Verification
Several properties are checked on every cycle:

- the enables are mutually exclusive;
- a write-class enable implies that WEL was set and BUSY was clear one cycle earlier;
- BUSY holds until a done pulse, and WEL is clear whenever BUSY falls;
- a status write never passes the SRP lock;
- nothing is enabled while asleep.

Some behaviour only the scenarios can show: the exact protected boundary for each BP level, the sector test at the last byte, alignment discards, the length of the recovery window, and that an ignored command left the status byte untouched. The bench's reference model covers these, including under long random command streams.

// File: rtl/flash_sg_pkg.sv
`timescale 1ns/1ps
package flash_sg_pkg;

  localparam logic [7:0] OPC_WSTAT   = 8'h01;
  localparam logic [7:0] OPC_PPROG   = 8'h02;
  localparam logic [7:0] OPC_READ    = 8'h03;
  localparam logic [7:0] OPC_WDIS    = 8'h04;
  localparam logic [7:0] OPC_RSTAT   = 8'h05;
  localparam logic [7:0] OPC_WEN     = 8'h06;
  localparam logic [7:0] OPC_FREAD   = 8'h0B;
  localparam logic [7:0] OPC_PARPROG = 8'h52;
  localparam logic [7:0] OPC_PARRD   = 8'h53;
  localparam logic [7:0] OPC_PARFRD  = 8'h5B;
  localparam logic [7:0] OPC_MFID    = 8'h90;
  localparam logic [7:0] OPC_STDID   = 8'h9F;
  localparam logic [7:0] OPC_IDWAKE  = 8'hAB;
  localparam logic [7:0] OPC_SLEEP   = 8'hB9;
  localparam logic [7:0] OPC_CERASE  = 8'hC7;
  localparam logic [7:0] OPC_PARERS  = 8'hD5;
  localparam logic [7:0] OPC_SERASE  = 8'hD8;

  typedef enum logic [3:0] {
    CL_NONE, CL_RSTAT, CL_READ, CL_IDWAKE, CL_WEN, CL_WDIS, CL_PPROG,
    CL_PARPROG, CL_SERASE, CL_CERASE, CL_PARERS, CL_WSTAT, CL_SLEEP
  } cmd_class_e;

  typedef struct packed {
    logic       srp;
    logic [1:0] rsvd;
    logic [2:0] bp;
    logic       wel;
    logic       busy;
  } stat_t;

  typedef struct packed {
    logic read;
    logic wen;
    logic wdis;
    logic prog;
    logic erase;
    logic wstat;
    logic sleep;
    logic wake;
  } acc_t;

  function automatic cmd_class_e classify(logic [7:0] op);
    case (op)
      OPC_RSTAT:                                                return CL_RSTAT;
      OPC_READ, OPC_FREAD, OPC_PARRD, OPC_PARFRD, OPC_MFID, OPC_STDID: return CL_READ;
      OPC_IDWAKE:                                               return CL_IDWAKE;
      OPC_WEN:                                                  return CL_WEN;
      OPC_WDIS:                                                 return CL_WDIS;
      OPC_PPROG:                                                return CL_PPROG;
      OPC_PARPROG:                                              return CL_PARPROG;
      OPC_SERASE:                                               return CL_SERASE;
      OPC_CERASE:                                               return CL_CERASE;
      OPC_PARERS:                                               return CL_PARERS;
      OPC_WSTAT:                                                return CL_WSTAT;
      OPC_SLEEP:                                                return CL_SLEEP;
      default:                                                  return CL_NONE;
    endcase
  endfunction

  // Upper-fraction protection: level n > 0 guards the top (2^aw >> (7-n)) bytes.
  function automatic logic prot_hit(logic [31:0] a, logic [2:0] bp, int aw);
    logic [32:0] span;
    logic [32:0] guard;
    if (bp == 3'd0) return 1'b0;
    span  = 33'd1 << aw;
    guard = span - (span >> (3'd7 - bp));
    return {1'b0, a} >= guard;
  endfunction

endpackage

// File: rtl/sg_cmd_gate.sv
`timescale 1ns/1ps
module sg_cmd_gate
  import flash_sg_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int SECTOR_W = 16
) (
  input  logic              valid,
  input  logic [7:0]        op,
  input  logic              aligned,
  input  logic [ADDR_W-1:0] addr,
  input  stat_t             stat,
  input  logic              wp_n,
  input  logic              pd,
  input  logic              waking,
  output acc_t              acc
);
  localparam logic [31:0] SECT_MASK = 32'((64'd1 << SECTOR_W) - 64'd1);

  cmd_class_e  cls;
  logic [31:0] a32;
  logic [31:0] sect_top;
  logic        page_hit;
  logic        sect_hit;
  logic        srp_lock;

  always_comb begin
    cls      = classify(op);
    a32      = 32'(addr);
    sect_top = a32 | SECT_MASK;
    page_hit = prot_hit(a32, stat.bp, ADDR_W);
    sect_hit = prot_hit(sect_top, stat.bp, ADDR_W);
    srp_lock = stat.srp & ~wp_n;
    acc      = '0;
    if (valid) begin
      if (pd) begin
        acc.wake = (cls == CL_IDWAKE);
      end else if (!waking) begin
        if (stat.busy) begin
          acc.read = (cls == CL_RSTAT);
        end else begin
          case (cls)
            CL_RSTAT, CL_READ, CL_IDWAKE: acc.read = 1'b1;
            CL_WEN:     acc.wen   = aligned;
            CL_WDIS:    acc.wdis  = aligned;
            CL_SLEEP:   acc.sleep = aligned;
            CL_WSTAT:   acc.wstat = aligned & stat.wel & ~srp_lock;
            CL_PPROG:   acc.prog  = aligned & stat.wel & ~page_hit;
            CL_PARPROG: acc.prog  = aligned & stat.wel;
            CL_SERASE:  acc.erase = aligned & stat.wel & ~sect_hit;
            CL_CERASE:  acc.erase = aligned & stat.wel & (stat.bp == 3'd0);
            CL_PARERS:  acc.erase = aligned & stat.wel;
            default:    acc       = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/sg_status_reg.sv
`timescale 1ns/1ps
module sg_status_reg
  import flash_sg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  acc_t       acc,
  input  logic [7:0] wdata,
  input  logic       op_done,
  output stat_t      stat,
  output logic       busy_rise,
  output logic       busy_fall
);
  logic       busy_q;
  logic       wel_q;
  logic [2:0] bp_q;
  logic       srp_q;

  assign busy_rise = acc.prog | acc.erase | acc.wstat;
  assign busy_fall = busy_q & op_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
      bp_q   <= 3'd0;
      srp_q  <= 1'b0;
    end else begin
      if (busy_fall) begin
        busy_q <= 1'b0;
        wel_q  <= 1'b0;
      end
      if (acc.wen)  wel_q <= 1'b1;
      if (acc.wdis) wel_q <= 1'b0;
      if (busy_rise) busy_q <= 1'b1;
      if (acc.wstat) begin
        srp_q <= wdata[7];
        bp_q  <= wdata[4:2];
      end
    end
  end

  always_comb begin
    stat.srp  = srp_q;
    stat.rsvd = 2'b00;
    stat.bp   = bp_q;
    stat.wel  = wel_q;
    stat.busy = busy_q;
  end
endmodule

// File: rtl/sg_wake_timer.sv
`timescale 1ns/1ps
module sg_wake_timer #(
  parameter int WAKE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_sleep,
  input  logic go_wake,
  output logic pd,
  output logic waking
);
  localparam int CW = $clog2(WAKE_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd  <= 1'b0;
      cnt <= '0;
    end else begin
      if (go_sleep) pd <= 1'b1;
      if (go_wake) begin
        pd  <= 1'b0;
        cnt <= CW'(WAKE_CYCLES);
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign waking = (cnt != '0);
endmodule

// File: rtl/flash_status_gate.sv
`timescale 1ns/1ps
module flash_status_gate
  import flash_sg_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int SECTOR_W    = 16,
  parameter int WAKE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic              cmd_aligned,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  input  logic              wp_n,
  input  logic              op_done,
  output logic [7:0]        status_o,
  output logic              en_read,
  output logic              en_prog,
  output logic              en_erase,
  output logic              en_stat_wr,
  output logic              en_pdown,
  output logic              asleep
);
  stat_t stat;
  acc_t  acc;
  logic  pd;
  logic  waking;
  logic  busy_rise;
  logic  busy_fall;

  sg_cmd_gate #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W)) gate_i (
    .valid   (cmd_valid),
    .op      (cmd_op),
    .aligned (cmd_aligned),
    .addr    (cmd_addr),
    .stat    (stat),
    .wp_n    (wp_n),
    .pd      (pd),
    .waking  (waking),
    .acc     (acc)
  );

  sg_status_reg sreg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .wdata     (cmd_wdata),
    .op_done   (op_done),
    .stat      (stat),
    .busy_rise (busy_rise),
    .busy_fall (busy_fall)
  );

  sg_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) wake_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_sleep (acc.sleep),
    .go_wake  (acc.wake),
    .pd       (pd),
    .waking   (waking)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_read    <= 1'b0;
      en_prog    <= 1'b0;
      en_erase   <= 1'b0;
      en_stat_wr <= 1'b0;
      en_pdown   <= 1'b0;
    end else begin
      en_read    <= acc.read;
      en_prog    <= acc.prog;
      en_erase   <= acc.erase;
      en_stat_wr <= acc.wstat;
      en_pdown   <= acc.sleep;
    end
  end

  assign status_o = stat;
  assign asleep   = pd | waking;
endmodule

// File: rtl/flash_status_gate_chk.sv
`timescale 1ns/1ps
module flash_status_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n,
  input logic       op_done,
  input logic [7:0] status_o,
  input logic       en_read,
  input logic       en_prog,
  input logic       en_erase,
  input logic       en_stat_wr,
  input logic       en_pdown,
  input logic       asleep
);
  logic wr_en;
  assign wr_en = en_prog | en_erase | en_stat_wr;

  AST_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({en_read, en_prog, en_erase, en_stat_wr, en_pdown})); // R10
  AST_WRITE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(status_o[1])); // R3
  AST_WRITE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> status_o[0]); // R3
  AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en | en_pdown) |-> !$past(status_o[0])); // R5
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[0] && !op_done) |=> status_o[0]); // R4
  AST_WEL_CLEARS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[0]) |-> !status_o[1]); // R4
  AST_SRP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    en_stat_wr |-> !($past(status_o[7]) && !$past(wp_n))); // R7
  AST_ASLEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(asleep) |-> !(en_read | wr_en | en_pdown)); // R9
endmodule

bind flash_status_gate flash_status_gate_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wp_n       (wp_n),
  .op_done    (op_done),
  .status_o   (status_o),
  .en_read    (en_read),
  .en_prog    (en_prog),
  .en_erase   (en_erase),
  .en_stat_wr (en_stat_wr),
  .en_pdown   (en_pdown),
  .asleep     (asleep)
);

// File: tb/flash_status_gate_tb_top.sv
`timescale 1ns/1ps
module flash_status_gate_tb_top;
  localparam int AW = 20;
  localparam int WK = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [7:0]    cmd_op = 8'h00;
  logic          cmd_aligned = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_wdata = 8'h00;
  logic          wp_n = 1'b1;
  logic          op_done = 1'b0;
  logic [7:0]    status_o;
  logic          en_read, en_prog, en_erase, en_stat_wr, en_pdown, asleep;

  flash_status_gate #(.ADDR_W(AW), .SECTOR_W(16), .WAKE_CYCLES(WK)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_aligned(cmd_aligned), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .wp_n(wp_n), .op_done(op_done), .status_o(status_o), .en_read(en_read),
    .en_prog(en_prog), .en_erase(en_erase), .en_stat_wr(en_stat_wr),
    .en_pdown(en_pdown), .asleep(asleep)
  );

  always #10 clk = ~clk;

  int    vectors = 0;
  int    misses = 0;
  string cur_req = "R1";

  // ---------------- behavioural reference model ----------------
  bit       m_busy, m_wel, m_srp, m_pd;
  bit [2:0] m_bp;
  int       m_wake;
  bit [4:0] m_en;   // {read, prog, erase, stwr, pdown}

  function automatic bit m_prot(longint a, bit [2:0] lvl);
    longint mem = longint'(1) << AW;
    if (lvl == 0) return 0;
    return a >= mem - mem / (longint'(1) << (7 - lvl));
  endfunction

  always @(posedge clk) begin : model
    bit ob, ow, opd;
    int owk;
    if (!rst_n) begin
      m_busy = 0; m_wel = 0; m_srp = 0; m_pd = 0; m_bp = 0; m_wake = 0; m_en = 0;
    end else begin
      ob = m_busy; ow = m_wel; opd = m_pd; owk = m_wake;
      m_en = 0;
      if (owk > 0) m_wake = owk - 1;
      if (ob && op_done) begin m_busy = 0; m_wel = 0; end
      if (cmd_valid) begin
        if (opd) begin
          if (cmd_op == 8'hAB) begin m_pd = 0; m_wake = WK; end
        end else if (owk > 0) begin
          m_en = 0;
        end else if (ob) begin
          if (cmd_op == 8'h05) m_en[4] = 1;
        end else begin
          case (cmd_op)
            8'h05, 8'h03, 8'h0B, 8'h53, 8'h5B, 8'h90, 8'h9F, 8'hAB: m_en[4] = 1;
            default: if (cmd_aligned) begin
              case (cmd_op)
                8'h06: m_wel = 1;
                8'h04: m_wel = 0;
                8'hB9: begin m_pd = 1; m_en[0] = 1; end
                8'h01: if (ow && !(m_srp && !wp_n)) begin
                  m_srp = cmd_wdata[7]; m_bp = cmd_wdata[4:2]; m_busy = 1; m_en[1] = 1;
                end
                8'h02: if (ow && !m_prot(longint'(cmd_addr), m_bp)) begin m_busy = 1; m_en[3] = 1; end
                8'h52: if (ow) begin m_busy = 1; m_en[3] = 1; end
                8'hD8: if (ow && !m_prot(longint'(cmd_addr) | 65535, m_bp)) begin m_busy = 1; m_en[2] = 1; end
                8'hC7: if (ow && m_bp == 0) begin m_busy = 1; m_en[2] = 1; end
                8'hD5: if (ow) begin m_busy = 1; m_en[2] = 1; end
                default: m_en = 0;
              endcase
            end
          endcase
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    logic [7:0] exp_s;
    logic [4:0] got_en;
    exp_s  = {m_srp, 2'b00, m_bp, m_wel, m_busy};
    got_en = {en_read, en_prog, en_erase, en_stat_wr, en_pdown};
    vectors++;
    if (status_o !== exp_s || got_en !== m_en || asleep !== (m_pd || m_wake > 0)) begin
      misses++;
      $display("FAIL %s model: status=%h en=%b asleep=%b expected status=%h en=%b asleep=%b",
               cur_req, status_o, got_en, asleep, exp_s, m_en, (m_pd || m_wake > 0));
    end
  end

  // ---------------- directed helpers ----------------
  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] op, input bit al, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_aligned = al; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  initial begin : watchdog
    #(20 * 150000);
    misses++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin : stim
    logic [7:0] ops [18];
    ops = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h0B, 8'h52, 8'h53,
            8'h5B, 8'h90, 8'h9F, 8'hAB, 8'hB9, 8'hC7, 8'hD5, 8'hD8, 8'h00};
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1 reset status", status_o, 8'h00);
    check("R1 reset asleep", {7'd0, asleep}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R3";
    cmd(8'h02, 1, 20'h00000, 8'h00);
    check("R3 program without WEL", {7'd0, en_prog}, 8'h00);
    cur_req = "R6";
    cmd(8'h06, 0, '0, 8'h00);
    check("R6 unaligned enable", status_o, 8'h00);
    cur_req = "R2";
    cmd(8'h06, 1, '0, 8'h00);
    check("R2 enable sets WEL", status_o, 8'h02);
    cmd(8'h04, 1, '0, 8'h00);
    check("R2 disable clears WEL", status_o, 8'h00);
    cmd(8'h06, 1, '0, 8'h00);

    cur_req = "R3";
    cmd(8'h02, 1, 20'h00100, 8'h00);
    check("R3 program enable", {7'd0, en_prog}, 8'h01);
    check("R3 busy set", status_o, 8'h03);
    cur_req = "R5";
    cmd(8'h04, 1, '0, 8'h00);
    check("R5 disable ignored while busy", status_o, 8'h03);
    cmd(8'h05, 0, '0, 8'h00);
    check("R5 status read while busy", {7'd0, en_read}, 8'h01);
    cmd(8'h03, 1, '0, 8'h00);
    check("R5 data read ignored while busy", {7'd0, en_read}, 8'h00);
    cur_req = "R4";
    done_pulse();
    check("R4 done clears busy and WEL", status_o, 8'h00);
    cmd(8'h06, 1, '0, 8'h00);
    done_pulse();
    check("R4 done while idle no effect", status_o, 8'h02);

    cur_req = "R7";
    cmd(8'h01, 1, '0, 8'hFF);
    check("R7 status write accepted", status_o, 8'h9F);
    done_pulse();
    check("R1 reserved bits read zero", status_o, 8'h9C);
    wp_n = 1'b0;
    cmd(8'h06, 1, '0, 8'h00);
    cmd(8'h01, 1, '0, 8'h00);
    check("R7 locked by SRP and pin", status_o, 8'h9E);
    check("R7 no status enable", {7'd0, en_stat_wr}, 8'h00);
    wp_n = 1'b1;
    cmd(8'h01, 1, '0, 8'h08);
    check("R7 write with pin high", status_o, 8'h0B);
    done_pulse();

    cur_req = "R8";
    cmd(8'h06, 1, '0, 8'h00);
    cmd(8'h02, 1, 20'hF8000, 8'h00);
    check("R8 program at protected base", status_o, 8'h0A);
    cmd(8'h02, 1, 20'hF7FFE, 8'h00);
    check("R8 program just below limit", status_o, 8'h0B);
    done_pulse();
    cmd(8'h06, 1, '0, 8'h00);
    cmd(8'hD8, 1, 20'hF0000, 8'h00);
    check("R8 sector with protected tail", status_o, 8'h0A);
    cmd(8'hC7, 1, '0, 8'h00);
    check("R8 chip erase with BP set", status_o, 8'h0A);
    cur_req = "R6";
    cmd(8'hD8, 0, 20'hE0000, 8'h00);
    check("R6 unaligned erase", status_o, 8'h0A);
    cur_req = "R8";
    cmd(8'hD8, 1, 20'hE0000, 8'h00);
    check("R8 unprotected sector erase", {7'd0, en_erase}, 8'h01);
    done_pulse();
    cmd(8'h06, 1, '0, 8'h00);
    cmd(8'h01, 1, '0, 8'h00);
    done_pulse();
    cmd(8'h06, 1, '0, 8'h00);
    cmd(8'hC7, 1, '0, 8'h00);
    check("R8 chip erase with BP clear", status_o, 8'h03);
    done_pulse();
    cur_req = "R3";
    cmd(8'h06, 1, '0, 8'h00);
    cmd(8'h52, 1, '0, 8'h00);
    check("R3 parameter program", {7'd0, en_prog}, 8'h01);
    done_pulse();
    cmd(8'h06, 1, '0, 8'h00);
    cmd(8'hD5, 1, '0, 8'h00);
    check("R3 parameter erase", {7'd0, en_erase}, 8'h01);
    done_pulse();

    cur_req = "R10";
    cmd(8'h9F, 0, '0, 8'h00);
    check("R10 id read unaligned", {7'd0, en_read}, 8'h01);
    cmd(8'h77, 1, '0, 8'h00);
    check("R10 unknown opcode", {3'd0, en_read, en_prog, en_erase, en_stat_wr, en_pdown}, 8'h00);

    cur_req = "R9";
    cmd(8'hB9, 1, '0, 8'h00);
    check("R9 sleep enable", {6'd0, en_pdown, asleep}, 8'h03);
    cmd(8'h05, 1, '0, 8'h00);
    check("R9 status read ignored asleep", {7'd0, en_read}, 8'h00);
    cmd(8'h06, 1, '0, 8'h00);
    check("R9 enable ignored asleep", status_o, 8'h00);
    cmd(8'hAB, 0, '0, 8'h00);
    check("R9 release starts recovery", {6'd0, en_read, asleep}, 8'h01);
    cmd(8'h05, 1, '0, 8'h00);
    check("R9 read ignored in recovery", {7'd0, en_read}, 8'h00);
    repeat (3) @(negedge clk);
    check("R9 recovery over", {7'd0, asleep}, 8'h00);
    cmd(8'h05, 1, '0, 8'h00);
    check("R9 read after recovery", {7'd0, en_read}, 8'h01);

    cur_req = "R5";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cmd_valid   = ($urandom_range(0, 2) == 0);
      cmd_op      = ops[$urandom_range(0, 17)];
      cmd_aligned = ($urandom_range(0, 3) != 0);
      cmd_addr    = AW'($urandom);
      cmd_wdata   = 8'($urandom);
      op_done     = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 15) == 0) wp_n = ~wp_n;
    end
    @(negedge clk);
    cmd_valid = 1'b0; op_done = 1'b0;
    repeat (2) @(negedge clk);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule